// File: doc/BRIEF.md
# Machine State Register Update Unit

This block owns the 64-bit machine state register (MSR) of a processor core and applies every architected change to it: the reset value, the changes made when an interrupt is taken, the return-from-interrupt restore, and both forms of move-to-MSR. It also serves move-from-MSR reads. Bits are numbered little-endian, with bit 0 as the least significant. The field positions are SF=63, HV=60, EE=15, PR=14, ME=12, IR=5, DR=4, RI=1 and LE=0.

Each operation copies only its own set of fields. Some bits are then forced according to the result, so the register is never simply loaded. When the problem-state bit PR is 1, the unit detects privileged operations and raises a privilege-fault flag. The faulting operation then has no effect on the register. Interrupt vectoring and the rest of the execute pipeline stay outside the block. The pipeline reacts to the fault flag by later pulsing the interrupt-take strobe.

Top module: `msr_update_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `msr_q` becomes 64'h8000_0000_0000_0001 (SF and LE set, all else clear), and `priv_fault` and `rd_data` become 0.
- R2: An edge with `irq_take`=1 sets SF and LE, clears PR, IR, DR and RI, and keeps every other bit.
- R3: `op_code`=2 (return) copies SF, EE, PR, ME, IR, DR, RI and LE from `saved_val`, and keeps all other bits, including HV and the partial-function bits.
- R4: `op_code`=1 (move-to-MSR) with `l_field`=1 copies only EE and RI from `src_val`.
- R5: `op_code`=1 with `l_field`=0 copies every bit from `src_val` except HV, ME and LE, which keep their values.
- R6: When a return or a move-to-MSR leaves PR at 1, EE, IR and DR are also set to 1.
- R7: `op_code`=3 (move-from-MSR) loads the whole pre-edge `msr_q` into `rd_data` at that edge. `rd_data` otherwise holds its value.
- R8: With PR=1, an accepted operation is privileged when `op_code` is 1, 2, 3 or 6. Codes 4 and 5 (move to or from an SPR) are privileged only when `spr_num_hi` (instruction bit 20, bit 4 of the SPR number) is 1. A privileged operation sets `priv_fault` for the following cycle. Codes 0 and 7, and all operations while PR=0, never fault.
- R9: A faulting operation leaves both `msr_q` and `rd_data` unchanged.
- R10: When `irq_take` and `op_valid` are both 1 at an edge, the interrupt update applies. The operation is ignored and raises no fault.
- R11: With `op_valid`=0, `op_code` and the data inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Decoded operation code (see R3 to R8) |
| src_val | input | 64 | Source register value for move-to-MSR |
| saved_val | input | 64 | Saved state value for return-from-interrupt |
| irq_take | input | 1 | Interrupt-entry strobe |
| l_field | input | 1 | Move-to-MSR L field (instruction bit 16) |
| spr_num_hi | input | 1 | Instruction bit 20, SPR number bit 4 |
| msr_q | output | 64 | Current MSR value |
| rd_data | output | 64 | Move-from-MSR result |
| priv_fault | output | 1 | Privileged-instruction fault, registered |

## Verification
Embedded assertions check the following on every cycle:
- the reset value;
- the interrupt-entry bit changes;
- the invariant that PR=1 implies EE, IR and DR are set;
- that a fault only follows a cycle with PR=1 and leaves the register unchanged;
- that the full move-to-MSR form preserves HV, ME and LE.

Only the bench's scenarios can show the exact copy masks of each operation, because the bench compares against its own reference model on every clock. The same applies to the partial-function bits that a return must keep, the SPR-bit privilege decode, interrupt priority over a simultaneous operation, and the read-back value.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int MSR_W   = 64;
  localparam int B_SF    = 63;
  localparam int B_HV    = 60;
  localparam int B_EE    = 15;
  localparam int B_PR    = 14;
  localparam int B_ME    = 12;
  localparam int B_IR    = 5;
  localparam int B_DR    = 4;
  localparam int B_RI    = 1;
  localparam int B_LE    = 0;

  typedef enum logic [2:0] {
    OPC_NONE  = 3'd0,
    OPC_MTMSR = 3'd1,
    OPC_RFI   = 3'd2,
    OPC_MFMSR = 3'd3,
    OPC_MTSPR = 3'd4,
    OPC_MFSPR = 3'd5,
    OPC_PRIV  = 3'd6,
    OPC_OTHER = 3'd7
  } msr_op_e;

  function automatic logic [MSR_W-1:0] bitm(input int pos);
    logic [MSR_W-1:0] m;
    m = '0;
    m[pos] = 1'b1;
    return m;
  endfunction

  localparam logic [MSR_W-1:0] M_RESET  = bitm(B_SF) | bitm(B_LE);
  localparam logic [MSR_W-1:0] M_IRQCLR = bitm(B_PR) | bitm(B_IR) | bitm(B_DR) | bitm(B_RI);
  localparam logic [MSR_W-1:0] M_RET    = bitm(B_SF) | bitm(B_EE) | bitm(B_PR) | bitm(B_ME)
                                        | bitm(B_IR) | bitm(B_DR) | bitm(B_RI) | bitm(B_LE);
  localparam logic [MSR_W-1:0] M_MT_ALL = ~(bitm(B_HV) | bitm(B_ME) | bitm(B_LE));
  localparam logic [MSR_W-1:0] M_MT_L1  = bitm(B_EE) | bitm(B_RI);
  localparam logic [MSR_W-1:0] M_PRSET  = bitm(B_EE) | bitm(B_IR) | bitm(B_DR);
endpackage

// File: rtl/msr_priv_check.sv
module msr_priv_check
  import msr_pkg::*;
(
  input  msr_op_e op,
  input  logic    spr_hi,
  input  logic    pr,
  output logic    fault
);
  logic is_priv;

  always_comb begin
    unique case (op)
      OPC_MTMSR, OPC_RFI, OPC_MFMSR, OPC_PRIV: is_priv = 1'b1;
      OPC_MTSPR, OPC_MFSPR:                    is_priv = spr_hi;
      default:                                 is_priv = 1'b0;
    endcase
    fault = pr & is_priv;
  end
endmodule

// File: rtl/msr_next_calc.sv
module msr_next_calc
  import msr_pkg::*;
(
  input  logic [MSR_W-1:0] cur,
  input  logic [MSR_W-1:0] src,
  input  logic [MSR_W-1:0] saved,
  input  logic             irq,
  input  msr_op_e          op,
  input  logic             l_sel,
  output logic [MSR_W-1:0] nxt,
  output logic             writes
);
  logic [MSR_W-1:0] merged;
  logic [MSR_W-1:0] mask;
  logic [MSR_W-1:0] pick;

  always_comb begin
    mask   = '0;
    pick   = src;
    writes = 1'b0;
    if (op == OPC_RFI) begin
      mask   = M_RET;
      pick   = saved;
      writes = 1'b1;
    end else if (op == OPC_MTMSR) begin
      mask   = l_sel ? M_MT_L1 : M_MT_ALL;
      writes = 1'b1;
    end
    merged = (cur & ~mask) | (pick & mask);
    if (merged[B_PR]) merged = merged | M_PRSET;

    if (irq) begin
      nxt    = (cur & ~M_IRQCLR) | M_RESET;
      writes = 1'b1;
    end else begin
      nxt = merged;
    end
  end
endmodule

// File: rtl/msr_update_unit.sv
module msr_update_unit
  import msr_pkg::*;
#(
  parameter int XLEN = MSR_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [2:0]      op_code,
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN-1:0] saved_val,
  input  logic            irq_take,
  input  logic            l_field,
  input  logic            spr_num_hi,
  output logic [XLEN-1:0] msr_q,
  output logic [XLEN-1:0] rd_data,
  output logic            priv_fault
);
  msr_op_e        op_eff;
  logic           fault_c;
  logic [XLEN-1:0] nxt_c;
  logic           writes_c;
  logic           accept;

  assign op_eff = op_valid ? msr_op_e'(op_code) : OPC_NONE;
  assign accept = op_valid & ~irq_take & ~fault_c;

  msr_priv_check u_priv (
    .op     (op_eff),
    .spr_hi (spr_num_hi),
    .pr     (msr_q[B_PR]),
    .fault  (fault_c)
  );

  msr_next_calc u_next (
    .cur    (msr_q),
    .src    (src_val),
    .saved  (saved_val),
    .irq    (irq_take),
    .op     (op_eff),
    .l_sel  (l_field),
    .nxt    (nxt_c),
    .writes (writes_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      msr_q      <= M_RESET;
      rd_data    <= '0;
      priv_fault <= 1'b0;
    end else begin
      priv_fault <= fault_c & ~irq_take;
      if (irq_take || (accept && writes_c)) msr_q <= nxt_c;
      if (accept && op_eff == OPC_MFMSR) rd_data <= msr_q;
    end
  end

  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (msr_q == M_RESET && rd_data == '0 && !priv_fault));

  // R2
  irq_entry_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> (msr_q[B_SF] && msr_q[B_LE] && !msr_q[B_PR] && !msr_q[B_IR]
                  && !msr_q[B_DR] && !msr_q[B_RI]
                  && msr_q[B_EE] == $past(msr_q[B_EE])
                  && msr_q[B_HV] == $past(msr_q[B_HV])));

  // R6
  pr_forces_xlate_chk: assert property (@(posedge clk) disable iff (rst)
    msr_q[B_PR] |-> (msr_q[B_EE] && msr_q[B_IR] && msr_q[B_DR]));

  // R8
  fault_needs_pr_chk: assert property (@(posedge clk) disable iff (rst)
    priv_fault |-> $past(msr_q[B_PR]));

  // R9
  fault_holds_chk: assert property (@(posedge clk) disable iff (rst)
    priv_fault |-> ($stable(msr_q) && $stable(rd_data)));

  // R5
  mt_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !irq_take && op_code == 3'd1 && !l_field && !msr_q[B_PR])
      |=> $stable({msr_q[B_HV], msr_q[B_ME], msr_q[B_LE]}));
endmodule

// File: tb/msr_update_unit_tb.sv
`timescale 1ns/1ps
module msr_update_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [63:0] src_val, saved_val;
  logic        irq_take, l_field, spr_num_hi;
  logic [63:0] msr_q, rd_data;
  logic        priv_fault;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string cur_req = "R1";

  logic [63:0] e_msr, e_rd;
  logic        e_pf;
  logic [63:0] lfsr = 64'h1234_5678_9ABC_DEF1;

  always #2.5 clk = ~clk;

  msr_update_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .src_val(src_val), .saved_val(saved_val), .irq_take(irq_take),
    .l_field(l_field), .spr_num_hi(spr_num_hi),
    .msr_q(msr_q), .rd_data(rd_data), .priv_fault(priv_fault)
  );

  function automatic bit is_priv(input logic [2:0] op, input logic sh);
    return (op == 3'd1) || (op == 3'd2) || (op == 3'd3) || (op == 3'd6)
        || (((op == 3'd4) || (op == 3'd5)) && sh);
  endfunction

  function automatic logic [63:0] force_pr(input logic [63:0] x);
    return x[14] ? (x | 64'h0000_0000_0000_8030) : x;
  endfunction

  task automatic cmp(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [2:0] op,
                      input logic [63:0] s, input logic [63:0] sv,
                      input logic irq, input logic l, input logic sh);
    logic [63:0] n_msr, n_rd;
    logic        n_pf, flt;
    @(negedge clk);
    rst = r; op_valid = v; op_code = op; src_val = s; saved_val = sv;
    irq_take = irq; l_field = l; spr_num_hi = sh;
    n_msr = e_msr; n_rd = e_rd; n_pf = 1'b0;
    if (r) begin
      n_msr = 64'h8000_0000_0000_0001; n_rd = '0;
    end else if (irq) begin
      n_msr = (e_msr & ~64'h0000_0000_0000_4032) | 64'h8000_0000_0000_0001;
    end else if (v) begin
      flt = e_msr[14] && is_priv(op, sh);
      n_pf = flt;
      if (!flt) begin
        case (op)
          3'd1: if (l) n_msr = force_pr((e_msr & ~64'h8002) | (s & 64'h8002));
                else   n_msr = force_pr((e_msr & 64'h1000_0000_0000_1001)
                                        | (s & ~64'h1000_0000_0000_1001));
          3'd2: n_msr = force_pr((e_msr & ~64'h8000_0000_0000_D033)
                                 | (sv & 64'h8000_0000_0000_D033));
          3'd3: n_rd = e_msr;
          default: ;
        endcase
      end
    end
    @(posedge clk);
    #1;
    e_msr = n_msr; e_rd = n_rd; e_pf = n_pf;
    cmp("msr_q", msr_q, e_msr);
    cmp("rd_data", rd_data, e_rd);
    cmp("priv_fault", {63'd0, priv_fault}, {63'd0, e_pf});
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 3'd0, '0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    e_msr = '0; e_rd = '0; e_pf = 1'b0;
    rst = 1'b1; op_valid = 0; op_code = 0; src_val = 0; saved_val = 0;
    irq_take = 0; l_field = 0; spr_num_hi = 0;
    cur_req = "R1";
    repeat (3) step(1'b1, 1'b0, 3'd0, '0, '0, 1'b0, 1'b0, 1'b0);
    idle();
    cur_req = "R7";
    step(1'b0, 1'b1, 3'd3, '0, '0, 1'b0, 1'b0, 1'b0);
    cur_req = "R11";
    step(1'b0, 1'b0, 3'd1, '1, '1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 3'd2, '1, '1, 1'b0, 1'b0, 1'b0);
    cur_req = "R4";
    step(1'b0, 1'b1, 3'd1, '1, '0, 1'b0, 1'b1, 1'b0);
    cur_req = "R5";
    step(1'b0, 1'b1, 3'd1, 64'hFFFF_FFFF_FFFF_BFFE, '0, 1'b0, 1'b0, 1'b0);
    cur_req = "R6";
    step(1'b0, 1'b1, 3'd1, 64'h0000_0000_0000_4000, '0, 1'b0, 1'b0, 1'b0);
    cur_req = "R8";
    step(1'b0, 1'b1, 3'd4, '0, '0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 3'd5, '0, '0, 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 3'd7, '0, '0, 1'b0, 1'b0, 1'b0);
    cur_req = "R9";
    step(1'b0, 1'b1, 3'd1, '0, '0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 3'd3, '0, '0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 3'd2, '0, '0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 3'd6, '0, '0, 1'b0, 1'b0, 1'b0);
    cur_req = "R10";
    step(1'b0, 1'b1, 3'd1, '0, '0, 1'b1, 1'b0, 1'b0);
    cur_req = "R2";
    step(1'b0, 1'b0, 3'd0, '0, '0, 1'b1, 1'b0, 1'b0);
    cur_req = "R3";
    step(1'b0, 1'b1, 3'd2, '0, 64'h1FFF_FFFF_FFFF_2FCC, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 3'd3, '0, '0, 1'b0, 1'b0, 1'b0);
    cur_req = "R6";
    step(1'b0, 1'b1, 3'd2, '0, 64'h0000_0000_0000_4000, 1'b0, 1'b0, 1'b0);
    cur_req = "R2";
    step(1'b0, 1'b0, 3'd0, '0, '0, 1'b1, 1'b0, 1'b0);
    cur_req = "R7";
    step(1'b0, 1'b1, 3'd3, '0, '0, 1'b0, 1'b0, 1'b0);
    cur_req = "R8";
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      step(1'b0, lfsr[0] | lfsr[9], lfsr[3:1], lfsr ^ {lfsr[31:0], lfsr[63:32]},
           {lfsr[40:0], lfsr[63:41]}, lfsr[6] & lfsr[7] & lfsr[8],
           lfsr[11], lfsr[12]);
    end
    cur_req = "R1";
    step(1'b1, 1'b1, 3'd1, '1, '1, 1'b1, 1'b0, 1'b0);
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule